// File: doc/BRIEF.md
# Byte-Serial Status Packet Transmitter

This block lets one subsystem report a status word to a central collector over a shared 8-bit byte-serial link. A single-cycle send strobe captures a target address, a 6-bit sequence number, two single-bit flags, up to three payload bytes and a count of how many of those bytes to send. The block then raises a request line and puts one packet byte on the data lines in every cycle that the request is high. The packet ends when the request falls.

A packet is always at least two bytes. The first byte is the address. The second byte packs the sequence number above the two flags. Then come zero to three payload bytes, least significant first. The collector answers the address byte with a start pulse. If the pulse is late, the transmitter holds the address byte until it arrives. The collector sees the end of a packet only as the falling request, so the block always leaves the request low between packets. Busy and done outputs let the sending subsystem pace its reports.

Top module: `status_pkt_tx`

## Requirements
- R1: After a synchronous active-high reset, whether applied when idle or in the middle of a packet, the request, busy and done outputs are low and the data lines are zero.
- R2: A send strobe taken while the block is not busy makes the request high in the next cycle. In that cycle the address, zero-extended to 8 bits, is on the data lines and busy is high. Busy stays high for as long as the request is high.
- R3: While the address byte is on the data lines and start is low, the request stays high and the data lines keep the address. The sequence byte follows in the cycle after start is seen high.
- R4: The byte after the address carries the sequence number in bits 7:2 and the two flags in bits 1:0. In the collector word this byte lands in bits 31:24.
- R5: After the sequence byte the block sends exactly the requested number (0 to 3) of payload bytes, lowest byte first, which map to collector word bits 7:0, 15:8 and 23:16. Payload bytes that are not sent read back as zero.
- R6: The request is high for one unbroken run of 2 + count + (cycles start was withheld) cycles. Whenever the request is low, the data lines are zero.
- R7: Done is high for exactly one cycle, the first cycle in which the request is low after a packet. Busy falls in the cycle after that.
- R8: A send strobe that arrives while busy, including the cycle in which done is high, is ignored. The packet in flight keeps its contents and no extra packet follows.
- R9: Once the request falls, it stays low for at least the next cycle, even when the send strobe is held high continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_i | input | 1 | Send strobe; captures the fields below when idle |
| addr_i | input | 8 | Target register address at the collector |
| seq_i | input | 6 | Sequence number |
| flags_i | input | 2 | Two single-bit status flags |
| payload_i | input | 24 | Payload, byte 0 in bits 7:0 |
| nbytes_i | input | 2 | Number of payload bytes to send (0..3) |
| start_i | input | 1 | Collector acknowledge of the address byte |
| req_o | output | 1 | Request; high exactly while packet bytes are driven |
| byte_o | output | 8 | Packet byte on the link |
| busy_o | output | 1 | Packet in progress; strobes are ignored |
| done_o | output | 1 | One-cycle pulse when the request drops |

## Verification
The hardest situations to reach from the ports are a strobe that lands in the single cycle where done is high, and an acknowledge that arrives several cycles after the address byte. The bench contains a collector model that withholds start for a chosen number of cycles per packet. It rebuilds each packet into a collector word from the request framing alone. The bench then fires a strobe exactly in the done cycle, another in the middle of a stalled address phase, and a strobe held high across several packets to probe the minimum gap between packets.

// File: rtl/spt_pkg.sv
`timescale 1ns/1ps
package spt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_SEQ  = 3'd2,
        ST_PAY  = 3'd3,
        ST_GAP  = 3'd4
    } spt_state_e;
endpackage

// File: rtl/spt_field_latch.sv
`timescale 1ns/1ps
module spt_field_latch #(
    parameter int BYTE_W    = 8,
    parameter int PAY_BYTES = 3,
    parameter int CNT_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_i,
    input  logic [BYTE_W-1:0]           seq_byte_i,
    input  logic [PAY_BYTES*BYTE_W-1:0] payload_i,
    input  logic [CNT_W-1:0]            count_i,
    output logic [BYTE_W-1:0]           seq_byte_o,
    output logic [PAY_BYTES*BYTE_W-1:0] payload_o,
    output logic [CNT_W-1:0]            count_o
);
    localparam int PAY_W   = PAY_BYTES * BYTE_W;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef struct packed {
        logic [BYTE_W-1:0] seq_byte;
        logic [PAY_W-1:0]  payload;
        logic [CNT_W-1:0]  count;
    } fields_t;

    fields_t f_d, f_q;
    logic [CNT_W-1:0] count_lim;

    // Clamp the count only when its width can express more than PAY_BYTES
    generate
        if (CNT_MAX > PAY_BYTES) begin : g_clamp
            always_comb begin
                count_lim = count_i;
                if (count_i > CNT_W'(PAY_BYTES)) begin
                    count_lim = CNT_W'(PAY_BYTES);
                end
            end
        end else begin : g_direct
            always_comb count_lim = count_i;
        end
    endgenerate

    always_comb begin
        f_d = f_q;
        if (load_i) begin
            f_d.seq_byte = seq_byte_i;
            f_d.payload  = payload_i;
            f_d.count    = count_lim;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign seq_byte_o = f_q.seq_byte;
    assign payload_o  = f_q.payload;
    assign count_o    = f_q.count;
endmodule

// File: rtl/spt_byte_sel.sv
`timescale 1ns/1ps
module spt_byte_sel #(
    parameter int BYTE_W    = 8,
    parameter int PAY_BYTES = 3,
    parameter int IDX_W     = 2
) (
    input  logic [PAY_BYTES*BYTE_W-1:0] payload_i,
    input  logic [IDX_W-1:0]            idx_i,
    output logic [BYTE_W-1:0]           byte_o
);
    logic [BYTE_W-1:0] lane [PAY_BYTES];

    generate
        for (genvar g = 0; g < PAY_BYTES; g++) begin : g_lane
            assign lane[g] = payload_i[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        byte_o = '0;
        for (int k = 0; k < PAY_BYTES; k++) begin
            if (idx_i == IDX_W'(k)) begin
                byte_o = lane[k];
            end
        end
    end
endmodule

// File: rtl/spt_frame_ctrl.sv
`timescale 1ns/1ps
module spt_frame_ctrl
    import spt_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send_i,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] addr_byte_i,
    input  logic [BYTE_W-1:0] seq_byte_i,
    input  logic [BYTE_W-1:0] pay_byte_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              load_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              req_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              busy_o,
    output logic              done_o
);
    typedef struct packed {
        spt_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic              req;
        logic [BYTE_W-1:0] dat;
        logic              done;
    } fc_t;

    fc_t r_d, r_q;
    logic load;

    assign load = (r_q.st == ST_IDLE) && send_i;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (send_i) begin
                    r_d.st  = ST_ADDR;
                    r_d.req = 1'b1;
                    r_d.dat = addr_byte_i;
                    r_d.idx = '0;
                end
            end
            ST_ADDR: begin
                if (start_i) begin
                    r_d.st  = ST_SEQ;
                    r_d.dat = seq_byte_i;
                end
            end
            ST_SEQ: begin
                if (count_i == '0) begin
                    r_d.st   = ST_GAP;
                    r_d.req  = 1'b0;
                    r_d.dat  = '0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st  = ST_PAY;
                    r_d.dat = pay_byte_i;
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_PAY: begin
                if (CNT_W'(r_q.idx) == count_i) begin
                    r_d.st   = ST_GAP;
                    r_d.req  = 1'b0;
                    r_d.dat  = '0;
                    r_d.done = 1'b1;
                end else begin
                    r_d.dat = pay_byte_i;
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_GAP: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.req = 1'b0;
                r_d.dat = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= ST_IDLE;
            r_q.idx  <= '0;
            r_q.req  <= 1'b0;
            r_q.dat  <= '0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign load_o = load;
    assign idx_o  = r_q.idx;
    assign req_o  = r_q.req;
    assign byte_o = r_q.dat;
    assign busy_o = (r_q.st != ST_IDLE);
    assign done_o = r_q.done;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_ADDR && !start_i) |=> (req_o && $stable(byte_o)))
        else $error("address byte not held"); // R3
    AST_IDLE_LINES_ZERO: assert property (@(posedge clk) disable iff (rst)
        !req_o |-> (byte_o == '0))
        else $error("data lines nonzero without request"); // R6
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!req_o && $past(req_o)))
        else $error("done without falling request"); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o)
        else $error("done longer than one cycle"); // R7
    AST_GAP_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !req_o)
        else $error("request rose right after falling"); // R9
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_o |-> busy_o)
        else $error("request without busy"); // R2
endmodule

// File: rtl/status_pkt_tx.sv
`timescale 1ns/1ps
module status_pkt_tx #(
    parameter int BYTE_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int SEQ_W     = 6,
    parameter int FLAG_W    = 2,
    parameter int PAY_BYTES = 3,
    localparam int PAY_W    = PAY_BYTES * BYTE_W,
    localparam int CNT_W    = $clog2(PAY_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SEQ_W-1:0]  seq_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [PAY_W-1:0]  payload_i,
    input  logic [CNT_W-1:0]  nbytes_i,
    input  logic              start_i,
    output logic              req_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int IDX_W = CNT_W;

    logic [BYTE_W-1:0] addr_byte;
    logic [BYTE_W-1:0] seq_byte_in;
    logic [BYTE_W-1:0] seq_byte_q;
    logic [PAY_W-1:0]  payload_q;
    logic [CNT_W-1:0]  count_q;
    logic [BYTE_W-1:0] pay_byte;
    logic [IDX_W-1:0]  idx;
    logic              load;

    assign addr_byte   = BYTE_W'(addr_i);
    assign seq_byte_in = BYTE_W'({seq_i, flags_i});

    spt_field_latch #(
        .BYTE_W    (BYTE_W),
        .PAY_BYTES (PAY_BYTES),
        .CNT_W     (CNT_W)
    ) latch_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load),
        .seq_byte_i (seq_byte_in),
        .payload_i  (payload_i),
        .count_i    (nbytes_i),
        .seq_byte_o (seq_byte_q),
        .payload_o  (payload_q),
        .count_o    (count_q)
    );

    spt_byte_sel #(
        .BYTE_W    (BYTE_W),
        .PAY_BYTES (PAY_BYTES),
        .IDX_W     (IDX_W)
    ) sel_i (
        .payload_i (payload_q),
        .idx_i     (idx),
        .byte_o    (pay_byte)
    );

    spt_frame_ctrl #(
        .BYTE_W (BYTE_W),
        .IDX_W  (IDX_W),
        .CNT_W  (CNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .send_i      (send_i),
        .start_i     (start_i),
        .addr_byte_i (addr_byte),
        .seq_byte_i  (seq_byte_q),
        .pay_byte_i  (pay_byte),
        .count_i     (count_q),
        .load_o      (load),
        .idx_o       (idx),
        .req_o       (req_o),
        .byte_o      (byte_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    AST_SEND_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_o && req_o && send_i) |=> busy_o)
        else $error("strobe during packet disturbed busy"); // R8
endmodule

// File: tb/status_pkt_tx_tb_top.sv
`timescale 1ns/1ps
module status_pkt_tx_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic send = 1'b0;
    logic start = 1'b0;
    logic [7:0]  addr = '0;
    logic [5:0]  seq = '0;
    logic [1:0]  fl = '0;
    logic [23:0] pay = '0;
    logic [1:0]  nb = '0;
    wire         req, busy, done;
    wire [7:0]   dat;

    always #4 clk = ~clk;

    status_pkt_tx dut_i (
        .clk(clk), .rst(rst), .send_i(send), .addr_i(addr), .seq_i(seq),
        .flags_i(fl), .payload_i(pay), .nbytes_i(nb), .start_i(start),
        .req_o(req), .byte_o(dat), .busy_o(busy), .done_o(done)
    );

    int n_chk = 0;
    int n_err = 0;

    // collector model
    int stall_cfg = 0, wait_cnt = 0, pos = 0, hi_cnt = 0, len_last = 0;
    int pkts = 0, low_run = 0, min_gap = 1000;
    int zero_err = 0, done_err = 0, hold_err = 0;
    bit acked = 0, prev_req = 0, seen_pkt = 0;
    logic [31:0] word_cap = '0, word_last = '0;
    logic [7:0]  addr_cap = '0, addr_last = '0;

    always @(negedge clk) begin
        if (rst) begin
            prev_req = 0; acked = 0; wait_cnt = 0; start = 0;
            low_run = 0; seen_pkt = 0;
        end else begin
            if (req) begin
                if (!prev_req) begin
                    word_cap = '0; pos = 0; hi_cnt = 0; addr_cap = dat;
                    if (seen_pkt && low_run < min_gap) min_gap = low_run;
                end
                hi_cnt++;
                if (!acked) begin
                    if (dat != addr_cap) hold_err++;
                    if (wait_cnt == stall_cfg) begin start = 1; acked = 1; end
                    else begin start = 0; wait_cnt++; end
                end else begin
                    start = 0;
                    case (pos)
                        0: word_cap[31:24] = dat;
                        1: word_cap[7:0]   = dat;
                        2: word_cap[15:8]  = dat;
                        3: word_cap[23:16] = dat;
                        default: ;
                    endcase
                    pos++;
                end
            end else begin
                if (prev_req) begin
                    pkts++; word_last = word_cap; addr_last = addr_cap;
                    len_last = hi_cnt; seen_pkt = 1; low_run = 0;
                end
                low_run++;
                if (dat != 8'h00) zero_err++;
                start = 0; acked = 0; wait_cnt = 0;
            end
            if (done !== (prev_req && !req)) done_err++;
            prev_req = req;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_pkt(input int base);
        for (int t = 0; t < 80; t++) begin
            if (pkts > base) break;
            tick();
        end
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 80; t++) begin
            if (!busy) break;
            tick();
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [5:0] s, input logic [1:0] f,
                                             input logic [23:0] p, input logic [1:0] n);
        logic [23:0] m;
        m = (n == 2'd0) ? 24'h0 : (n == 2'd1) ? 24'hFF : (n == 2'd2) ? 24'hFFFF : 24'hFFFFFF;
        return {s, f, p & m};
    endfunction

    task automatic drive(input logic [7:0] a, input logic [5:0] s, input logic [1:0] f,
                         input logic [23:0] p, input logic [1:0] n);
        addr = a; seq = s; fl = f; pay = p; nb = n;
    endtask

    task automatic run_vec(input logic [7:0] a, input logic [5:0] s, input logic [1:0] f,
                           input logic [23:0] p, input logic [1:0] n, input int st);
        int base;
        wait_idle();
        stall_cfg = st; base = pkts;
        drive(a, s, f, p, n); send = 1;
        tick(); send = 0;
        chk(req && busy && dat == a, "R2 request/address/busy", {8'h0, dat, 7'h0, busy, 7'h0, req},
            {8'h0, a, 8'h1, 8'h1});
        drive(~a, ~s, ~f, ~p, ~n); // inputs change after the strobe
        wait_pkt(base);
        chk(addr_last == a, "R2 address byte", {24'h0, addr_last}, {24'h0, a});
        chk(word_last == exp_word(s, f, p, n), "R4/R5 collector word", word_last, exp_word(s, f, p, n));
        chk(len_last == 2 + n + st, "R6 request length", len_last, 2 + n + st);
        chk(done && busy, "R7 done with busy", {30'h0, done, busy}, 32'h3);
        tick();
        chk(!done && !busy, "R7 done pulse ends and busy drops", {30'h0, done, busy}, 32'h0);
    endtask

    // fields: addr[43:36] seq[35:30] flags[29:28] payload[27:4] count[3:2] stall[1:0]
    localparam logic [43:0] VECS [8] = '{
        {8'h12, 6'h05, 2'b10, 24'hABCDEF, 2'd3, 2'd0},
        {8'hFF, 6'h3F, 2'b11, 24'h123456, 2'd0, 2'd0},
        {8'h00, 6'h00, 2'b01, 24'h00FF80, 2'd1, 2'd1},
        {8'h7E, 6'h2A, 2'b00, 24'h0A0B0C, 2'd2, 2'd2},
        {8'h81, 6'h15, 2'b11, 24'hFFFFFF, 2'd3, 2'd3},
        {8'h40, 6'h01, 2'b00, 24'h000000, 2'd3, 2'd0},
        {8'h33, 6'h20, 2'b10, 24'h9ABCDE, 2'd1, 2'd0},
        {8'hC3, 6'h0A, 2'b01, 24'h55AA33, 2'd2, 2'd1}
    };

    initial begin
        int base;
        repeat (3) tick();
        // R1: reset state
        chk(!req && !busy && !done && dat == 8'h0, "R1 outputs during reset",
            {dat, 5'h0, req, busy, done}, 32'h0);
        rst = 0;
        tick();
        chk(!req && !busy && !done && dat == 8'h0, "R1 outputs after reset",
            {dat, 5'h0, req, busy, done}, 32'h0);

        for (int i = 0; i < 8; i++) begin
            run_vec(VECS[i][43:36], VECS[i][35:30], VECS[i][29:28], VECS[i][27:4],
                    VECS[i][3:2], int'(VECS[i][1:0]));
        end

        // R8: strobe during a stalled address phase is ignored
        wait_idle();
        stall_cfg = 3; base = pkts;
        drive(8'h5A, 6'h11, 2'b01, 24'h010203, 2'd2); send = 1;
        tick(); send = 0;
        tick();
        drive(8'hA5, 6'h22, 2'b10, 24'hF0F0F0, 2'd3); send = 1;
        tick(); send = 0;
        wait_pkt(base);
        chk(addr_last == 8'h5A, "R8 address kept", {24'h0, addr_last}, 32'h5A);
        chk(word_last == 32'h45000203, "R8 word kept", word_last, 32'h45000203);
        repeat (10) tick();
        chk(pkts == base + 1 && !req, "R8 no extra packet", pkts, base + 1);

        // R8: strobe in the done cycle is ignored
        stall_cfg = 0; base = pkts;
        drive(8'h21, 6'h03, 2'b00, 24'h0, 2'd0); send = 1;
        tick(); send = 0;
        wait_pkt(base);
        chk(done == 1'b1, "R7 done observed", {31'h0, done}, 32'h1);
        drive(8'h99, 6'h07, 2'b11, 24'h777777, 2'd3); send = 1;
        tick(); send = 0;
        repeat (10) tick();
        chk(pkts == base + 1 && !req, "R8 strobe in done cycle ignored", pkts, base + 1);

        // R9: strobe held high across several packets
        min_gap = 1000; base = pkts;
        drive(8'h0F, 6'h01, 2'b01, 24'h0, 2'd0); send = 1;
        repeat (40) tick();
        send = 0;
        wait_idle();
        tick();
        chk(pkts >= base + 3, "R9 back-to-back packets sent", pkts, base + 3);
        chk(min_gap >= 1 && min_gap < 1000, "R9 request low between packets", min_gap, 1);
        chk(word_last == 32'h05000000, "R4 seq byte in held-strobe packets", word_last, 32'h05000000);

        // R1: reset in the middle of a packet
        stall_cfg = 3;
        drive(8'h44, 6'h04, 2'b00, 24'h112233, 2'd3); send = 1;
        tick(); send = 0;
        tick();
        rst = 1;
        repeat (3) tick();
        chk(!req && !busy && !done && dat == 8'h0, "R1 reset mid-packet",
            {dat, 5'h0, req, busy, done}, 32'h0);
        rst = 0;
        repeat (3) tick();
        chk(!req && !busy, "R1 stays idle after reset", {30'h0, req, busy}, 32'h0);

        chk(hold_err == 0, "R3 address held while start withheld", hold_err, 0);
        chk(zero_err == 0, "R6 data lines zero without request", zero_err, 0);
        chk(done_err == 0, "R7 done matches request fall", done_err, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule